// File: doc/BRIEF.md
# Indexed System Register Access Decoder

This block classifies a privileged access to one bank of up to sixteen indexed system registers. Each request carries the instruction encoding fields (op0, op1, CRn, CRm, op2), the current privilege level (0 to 3), a three-bit nested-virtualisation control vector and two register-interface enable bits, one for level 2 and one for level 3. The block returns exactly one verdict for the request. The verdict is one of the following: the encoding does not address this bank, the access is undefined, the access traps to a higher level with a syndrome class, the access is redirected to a memory slot, or the access reaches a register directly at a decoded index.

Read and write requests are decoded the same way. The direction bit travels with the result, so the core that consumes the verdict can perform the register or memory transfer itself. Every verdict is registered, and appears one clock after the request strobe.

Top module: `sysreg_access_dec`

## Requirements
- R1: A request addresses the bank only when op0 = 3, op1 = 4, CRn = 12 and CRm[3:1] = 3'b110. Any other encoding raises `rsp_nomatch` and no other verdict.
- R2: The register index is {CRm[0], op2[2:0]}, which gives 0 to 15. A matching request whose index is greater than or equal to `NUM_REGS` (default 12) is undefined at every privilege level.
- R3: A matching, in-range request at privilege level 0 is undefined.
- R4: At level 1, when `nv_ctrl[2]` and `nv_ctrl[0]` are both 1, the access is redirected to memory. `rsp_mem_addr` = 0x400 + 8 × index, and `rsp_index` carries the index.
- R5: At level 1, when `nv_ctrl[0]` = 1 and `nv_ctrl[2]` = 0, the access traps to level 2 with class 0x18. When `nv_ctrl[0]` = 0, the access is undefined, whatever the value of `nv_ctrl[2]`.
- R6: At level 2, `sre_l2` = 0 causes a trap to level 2 with class 0x18. `sre_l2` = 1 gives direct access with `rsp_index` set. `sre_l3` has no effect at this level.
- R7: At level 3, `sre_l3` = 0 causes a trap to level 3 with class 0x18. `sre_l3` = 1 gives direct access with `rsp_index` set. `sre_l2` has no effect at this level.
- R8: Exactly one of `rsp_nomatch`, `rsp_undef`, `rsp_trap`, `rsp_mem` and `rsp_direct` is 1 in the cycle after a request strobe. All five are 0 when no result is presented. Payload fields are 0 unless their verdict is active: trap level and class with a trap, address with a redirect, index with a redirect or a direct access.
- R9: `rsp_write` equals the `req_write` of the request being answered, and the direction does not change the verdict.
- R10: While reset is held, and after it is released with no request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | Direction: 1 write, 0 read |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| priv_lvl | input | 2 | Current privilege level 0 to 3 |
| nv_ctrl | input | 3 | Nested-virtualisation control vector |
| sre_l2 | input | 1 | Register interface enable for level 2 |
| sre_l3 | input | 1 | Register interface enable for level 3 |
| rsp_valid | output | 1 | Verdict present this cycle |
| rsp_write | output | 1 | Direction of the answered request |
| rsp_nomatch | output | 1 | Encoding does not address this bank |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps |
| rsp_trap_lvl | output | 2 | Target level of the trap |
| rsp_trap_class | output | 6 | Syndrome class of the trap |
| rsp_mem | output | 1 | Access redirected to memory |
| rsp_mem_addr | output | 16 | Memory offset of the redirect |
| rsp_direct | output | 1 | Direct register access |
| rsp_index | output | 4 | Register index for redirect or direct access |

## Verification
The checker assumes that each result answers the request sampled on the previous clock. Its properties therefore relate every verdict to the past values of the privilege level, the control vector and the encoding fields. These checks hold only if the inputs are stable across the capturing edge. The bench keeps to this assumption by changing every input on the falling edge, and it answers each request strobe on the next rising edge. Privilege levels cover all four values. The control vector also takes don't-care combinations, so that each pattern is shown to depend only on bits 2 and 0.

// File: rtl/sysreg_dec_pkg.sv
package sysreg_dec_pkg;

  localparam int unsigned IDX_W   = 4;
  localparam int unsigned CLASS_W = 6;
  localparam int unsigned LVL_W   = 2;

  localparam logic [1:0] BANK_OP0     = 2'd3;
  localparam logic [2:0] BANK_OP1     = 3'd4;
  localparam logic [3:0] BANK_CRN     = 4'd12;
  localparam logic [2:0] BANK_CRM_HI  = 3'b110;

  typedef enum logic [2:0] {
    VERDICT_NOMATCH = 3'd0,
    VERDICT_UNDEF   = 3'd1,
    VERDICT_TRAP    = 3'd2,
    VERDICT_MEM     = 3'd3,
    VERDICT_DIRECT  = 3'd4
  } verdict_e;

  typedef struct packed {
    verdict_e                 kind;
    logic [LVL_W-1:0]         trap_lvl;
    logic [IDX_W-1:0]         index;
  } decision_t;

endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match
  import sysreg_dec_pkg::*;
(
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output logic             hit,
  output logic [IDX_W-1:0] index
);

  always_comb begin
    hit   = (op0 == BANK_OP0) && (op1 == BANK_OP1) &&
            (crn == BANK_CRN) && (crm[3:1] == BANK_CRM_HI);
    index = {crm[0], op2};
  end

endmodule

// File: rtl/sysreg_priv_policy.sv
module sysreg_priv_policy
  import sysreg_dec_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic             hit,
  input  logic [IDX_W-1:0] index,
  input  logic [1:0]       priv,
  input  logic [2:0]       nv,
  input  logic             sre2,
  input  logic             sre3,
  output decision_t        dec
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic in_range;
  logic nv_redirect;
  logic nv_trap;

  always_comb begin
    in_range    = {1'b0, index} < LIMIT;
    nv_redirect = nv[2] & nv[0];
    nv_trap     = nv[0];
    dec         = '{kind: VERDICT_UNDEF, trap_lvl: '0, index: '0};
    if (!hit) begin
      dec.kind = VERDICT_NOMATCH;
    end else if (in_range) begin
      unique case (priv)
        2'd0: dec.kind = VERDICT_UNDEF;
        2'd1: begin
          if (nv_redirect) begin
            dec.kind  = VERDICT_MEM;
            dec.index = index;
          end else if (nv_trap) begin
            dec.kind     = VERDICT_TRAP;
            dec.trap_lvl = 2'd2;
          end
        end
        2'd2: begin
          if (sre2) begin
            dec.kind  = VERDICT_DIRECT;
            dec.index = index;
          end else begin
            dec.kind     = VERDICT_TRAP;
            dec.trap_lvl = 2'd2;
          end
        end
        default: begin
          if (sre3) begin
            dec.kind  = VERDICT_DIRECT;
            dec.index = index;
          end else begin
            dec.kind     = VERDICT_TRAP;
            dec.trap_lvl = 2'd3;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sysreg_slot_addr.sv
module sysreg_slot_addr
  import sysreg_dec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MEM_BASE = 32'h400,
  parameter int unsigned STRIDE   = 8
) (
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(MEM_BASE);
  localparam bit POW2 = (STRIDE != 0) && ((STRIDE & (STRIDE - 1)) == 0);

  generate
    if (POW2) begin : g_shift
      localparam int unsigned SH = $clog2(STRIDE);
      assign addr = BASE_V + (ADDR_W'(index) << SH);
    end else begin : g_mult
      localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
      assign addr = BASE_V + ADDR_W'(ADDR_W'(index) * STRIDE_V);
    end
  endgenerate

endmodule

// File: rtl/sysreg_access_dec.sv
module sysreg_access_dec
  import sysreg_dec_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 12,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MEM_BASE   = 32'h400,
  parameter int unsigned STRIDE     = 8,
  parameter int unsigned TRAP_CLASS = 32'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        enc_op0,
  input  logic [2:0]        enc_op1,
  input  logic [3:0]        enc_crn,
  input  logic [3:0]        enc_crm,
  input  logic [2:0]        enc_op2,
  input  logic [1:0]        priv_lvl,
  input  logic [2:0]        nv_ctrl,
  input  logic              sre_l2,
  input  logic              sre_l3,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_nomatch,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [1:0]        rsp_trap_lvl,
  output logic [5:0]        rsp_trap_class,
  output logic              rsp_mem,
  output logic [ADDR_W-1:0] rsp_mem_addr,
  output logic              rsp_direct,
  output logic [3:0]        rsp_index
);

  localparam logic [CLASS_W-1:0] CLASS_V = CLASS_W'(TRAP_CLASS);

  logic             hit;
  logic [IDX_W-1:0] raw_index;
  decision_t        dec;
  logic [ADDR_W-1:0] slot_addr;

  sysreg_enc_match u_match (
    .op0   (enc_op0),
    .op1   (enc_op1),
    .crn   (enc_crn),
    .crm   (enc_crm),
    .op2   (enc_op2),
    .hit   (hit),
    .index (raw_index)
  );

  sysreg_priv_policy #(
    .NUM_REGS (NUM_REGS)
  ) u_policy (
    .hit   (hit),
    .index (raw_index),
    .priv  (priv_lvl),
    .nv    (nv_ctrl),
    .sre2  (sre_l2),
    .sre3  (sre_l3),
    .dec   (dec)
  );

  sysreg_slot_addr #(
    .ADDR_W   (ADDR_W),
    .MEM_BASE (MEM_BASE),
    .STRIDE   (STRIDE)
  ) u_addr (
    .index (dec.index),
    .addr  (slot_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_write      <= 1'b0;
      rsp_nomatch    <= 1'b0;
      rsp_undef      <= 1'b0;
      rsp_trap       <= 1'b0;
      rsp_trap_lvl   <= '0;
      rsp_trap_class <= '0;
      rsp_mem        <= 1'b0;
      rsp_mem_addr   <= '0;
      rsp_direct     <= 1'b0;
      rsp_index      <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_write      <= req_valid & req_write;
      rsp_nomatch    <= req_valid && (dec.kind == VERDICT_NOMATCH);
      rsp_undef      <= req_valid && (dec.kind == VERDICT_UNDEF);
      rsp_trap       <= req_valid && (dec.kind == VERDICT_TRAP);
      rsp_mem        <= req_valid && (dec.kind == VERDICT_MEM);
      rsp_direct     <= req_valid && (dec.kind == VERDICT_DIRECT);
      rsp_trap_lvl   <= (req_valid && dec.kind == VERDICT_TRAP) ? dec.trap_lvl : '0;
      rsp_trap_class <= (req_valid && dec.kind == VERDICT_TRAP) ? CLASS_V : '0;
      rsp_mem_addr   <= (req_valid && dec.kind == VERDICT_MEM) ? slot_addr : '0;
      rsp_index      <= req_valid ? dec.index : '0;
    end
  end

endmodule

// File: rtl/sysreg_access_dec_chk.sv
module sysreg_access_dec_chk #(
  parameter int unsigned NUM_REGS   = 12,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MEM_BASE   = 32'h400,
  parameter int unsigned STRIDE     = 8,
  parameter int unsigned TRAP_CLASS = 32'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        enc_crm,
  input logic [2:0]        enc_op2,
  input logic [1:0]        priv_lvl,
  input logic [2:0]        nv_ctrl,
  input logic              rsp_valid,
  input logic              rsp_write,
  input logic              rsp_nomatch,
  input logic              rsp_undef,
  input logic              rsp_trap,
  input logic [1:0]        rsp_trap_lvl,
  input logic [5:0]        rsp_trap_class,
  input logic              rsp_mem,
  input logic [ADDR_W-1:0] rsp_mem_addr,
  input logic              rsp_direct,
  input logic [3:0]        rsp_index
);

  logic [4:0] verdicts;
  assign verdicts = {rsp_nomatch, rsp_undef, rsp_trap, rsp_mem, rsp_direct};

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(verdicts) == 1);

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> verdicts == 5'b0);

  assert_answers_req_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  assert_dir_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_write == $past(req_write));

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_nomatch &&
     ({1'b0, $past(enc_crm[0]), $past(enc_op2)} >= 5'(NUM_REGS))) |-> rsp_undef);

  assert_lvl0_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_nomatch && $past(priv_lvl) == 2'd0) |-> rsp_undef);

  assert_redirect_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_mem |-> ($past(priv_lvl) == 2'd1 && $past(nv_ctrl[2]) && $past(nv_ctrl[0]) &&
                 rsp_mem_addr == ADDR_W'(MEM_BASE + STRIDE * rsp_index)));

  assert_trap_class_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_trap_class == 6'(TRAP_CLASS) &&
                  (rsp_trap_lvl == 2'd2 || rsp_trap_lvl == 2'd3)));

  assert_trap_l3_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_trap_lvl == 2'd3) |-> $past(priv_lvl) == 2'd3);

  assert_direct_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_direct |-> $past(priv_lvl) >= 2'd2);

endmodule

bind sysreg_access_dec sysreg_access_dec_chk #(
  .NUM_REGS   (NUM_REGS),
  .ADDR_W     (ADDR_W),
  .MEM_BASE   (MEM_BASE),
  .STRIDE     (STRIDE),
  .TRAP_CLASS (TRAP_CLASS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .enc_crm        (enc_crm),
  .enc_op2        (enc_op2),
  .priv_lvl       (priv_lvl),
  .nv_ctrl        (nv_ctrl),
  .rsp_valid      (rsp_valid),
  .rsp_write      (rsp_write),
  .rsp_nomatch    (rsp_nomatch),
  .rsp_undef      (rsp_undef),
  .rsp_trap       (rsp_trap),
  .rsp_trap_lvl   (rsp_trap_lvl),
  .rsp_trap_class (rsp_trap_class),
  .rsp_mem        (rsp_mem),
  .rsp_mem_addr   (rsp_mem_addr),
  .rsp_direct     (rsp_direct),
  .rsp_index      (rsp_index)
);

// File: tb/tb_sysreg_access_dec.sv
module tb_sysreg_access_dec;

  localparam int NREG = 12;

  typedef struct packed {
    logic        wr;
    logic        nomatch;
    logic        undef;
    logic        trap;
    logic [1:0]  lvl;
    logic [5:0]  cls;
    logic        mem;
    logic [15:0] addr;
    logic        direct;
    logic [3:0]  idx;
  } rsp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] enc_op0 = '0;
  logic [2:0] enc_op1 = '0;
  logic [3:0] enc_crn = '0, enc_crm = '0;
  logic [2:0] enc_op2 = '0;
  logic [1:0] priv_lvl = '0;
  logic [2:0] nv_ctrl = '0;
  logic sre_l2 = 1'b0, sre_l3 = 1'b0;

  logic rsp_valid, rsp_write, rsp_nomatch, rsp_undef, rsp_trap, rsp_mem, rsp_direct;
  logic [1:0]  rsp_trap_lvl;
  logic [5:0]  rsp_trap_class;
  logic [15:0] rsp_mem_addr;
  logic [3:0]  rsp_index;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  rsp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sysreg_access_dec #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm),
    .enc_op2(enc_op2), .priv_lvl(priv_lvl), .nv_ctrl(nv_ctrl),
    .sre_l2(sre_l2), .sre_l3(sre_l3),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_nomatch(rsp_nomatch),
    .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_trap_lvl(rsp_trap_lvl),
    .rsp_trap_class(rsp_trap_class), .rsp_mem(rsp_mem), .rsp_mem_addr(rsp_mem_addr),
    .rsp_direct(rsp_direct), .rsp_index(rsp_index)
  );

  function automatic rsp_t observed();
    rsp_t r;
    r = '{wr: rsp_write, nomatch: rsp_nomatch, undef: rsp_undef, trap: rsp_trap,
          lvl: rsp_trap_lvl, cls: rsp_trap_class, mem: rsp_mem, addr: rsp_mem_addr,
          direct: rsp_direct, idx: rsp_index};
    return r;
  endfunction

  function automatic rsp_t model(logic wr, logic [1:0] o0, logic [2:0] o1, logic [3:0] cn,
                                 logic [3:0] cm, logic [2:0] o2, logic [1:0] pl,
                                 logic [2:0] nv, logic s2, logic s3);
    rsp_t r;
    int   idx;
    r = '0;
    r.wr = wr;
    idx = {cm[0], o2};
    if (!(o0 == 2'd3 && o1 == 3'd4 && cn == 4'd12 && cm[3:1] == 3'b110)) r.nomatch = 1'b1;
    else if (idx >= NREG) r.undef = 1'b1;
    else if (pl == 2'd0) r.undef = 1'b1;
    else if (pl == 2'd1) begin
      if (nv[2] && nv[0]) begin
        r.mem = 1'b1; r.addr = 16'(16'h400 + 8 * idx); r.idx = 4'(idx);
      end else if (nv[0]) begin
        r.trap = 1'b1; r.lvl = 2'd2; r.cls = 6'h18;
      end else r.undef = 1'b1;
    end else if (pl == 2'd2) begin
      if (s2) begin r.direct = 1'b1; r.idx = 4'(idx); end
      else begin r.trap = 1'b1; r.lvl = 2'd2; r.cls = 6'h18; end
    end else begin
      if (s3) begin r.direct = 1'b1; r.idx = 4'(idx); end
      else begin r.trap = 1'b1; r.lvl = 2'd3; r.cls = 6'h18; end
    end
    return r;
  endfunction

  task automatic send(string tag, logic wr, logic [1:0] o0, logic [2:0] o1, logic [3:0] cn,
                      logic [3:0] cm, logic [2:0] o2, logic [1:0] pl, logic [2:0] nv,
                      logic s2, logic s3);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    enc_op0 = o0; enc_op1 = o1; enc_crn = cn; enc_crm = cm; enc_op2 = o2;
    priv_lvl = pl; nv_ctrl = nv; sre_l2 = s2; sre_l3 = s3;
    exp_q.push_back(model(wr, o0, o1, cn, cm, o2, pl, nv, s2, s3));
    tag_q.push_back(tag);
  endtask

  task automatic hit(string tag, logic wr, logic [3:0] idx, logic [1:0] pl,
                     logic [2:0] nv, logic s2, logic s3);
    send(tag, wr, 2'd3, 3'd4, 4'd12, {3'b110, idx[3]}, idx[2:0], pl, nv, s2, s3);
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      rsp_t  got, exp;
      string tag;
      got = observed();
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected result got=%h expected=no result", got);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired got=%0d expected<5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check_idle(string tag);
    @(negedge clk);
    checks++;
    if (observed() !== '0 || rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s got=%h valid=%b expected=0", tag, observed(), rsp_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== '0 || rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 in reset got=%h expected=0", observed());
    end
    rst = 1'b0;
    check_idle("R10 after release");
    // R1 encodings off the bank
    send("R1 op0", 1'b0, 2'd2, 3'd4, 4'd12, 4'b1100, 3'd0, 2'd2, 3'b000, 1'b1, 1'b1);
    send("R1 op1", 1'b1, 2'd3, 3'd5, 4'd12, 4'b1100, 3'd1, 2'd3, 3'b000, 1'b1, 1'b1);
    send("R1 crn", 1'b0, 2'd3, 3'd4, 4'd11, 4'b1101, 3'd2, 2'd2, 3'b000, 1'b1, 1'b1);
    send("R1 crm", 1'b0, 2'd3, 3'd4, 4'd12, 4'b1010, 3'd0, 2'd2, 3'b000, 1'b1, 1'b1);
    // R2 index range
    hit("R2 idx12", 1'b0, 4'd12, 2'd2, 3'b000, 1'b1, 1'b1);
    hit("R2 idx15", 1'b1, 4'd15, 2'd3, 3'b000, 1'b1, 1'b1);
    hit("R2 idx15 l1", 1'b0, 4'd15, 2'd1, 3'b101, 1'b1, 1'b1);
    hit("R2 idx11", 1'b0, 4'd11, 2'd2, 3'b000, 1'b1, 1'b0);
    // R3 level 0
    hit("R3 l0", 1'b0, 4'd3, 2'd0, 3'b101, 1'b1, 1'b1);
    hit("R3 l0 wr", 1'b1, 4'd0, 2'd0, 3'b111, 1'b0, 1'b0);
    // R4 redirect
    hit("R4 nv101 idx0", 1'b0, 4'd0, 2'd1, 3'b101, 1'b0, 1'b0);
    hit("R4 nv111 idx5", 1'b1, 4'd5, 2'd1, 3'b111, 1'b1, 1'b1);
    hit("R4 nv101 idx11", 1'b0, 4'd11, 2'd1, 3'b101, 1'b0, 1'b1);
    // R5 level 1 trap / undef
    hit("R5 nv001", 1'b0, 4'd2, 2'd1, 3'b001, 1'b1, 1'b1);
    hit("R5 nv011", 1'b1, 4'd9, 2'd1, 3'b011, 1'b0, 1'b0);
    hit("R5 nv000", 1'b0, 4'd4, 2'd1, 3'b000, 1'b1, 1'b1);
    hit("R5 nv100", 1'b0, 4'd4, 2'd1, 3'b100, 1'b1, 1'b1);
    hit("R5 nv110", 1'b1, 4'd7, 2'd1, 3'b110, 1'b1, 1'b1);
    // R6 level 2
    hit("R6 sre2 off", 1'b0, 4'd6, 2'd2, 3'b101, 1'b0, 1'b1);
    hit("R6 sre2 on sre3 off", 1'b1, 4'd8, 2'd2, 3'b000, 1'b1, 1'b0);
    // R7 level 3
    hit("R7 sre3 off", 1'b0, 4'd1, 2'd3, 3'b000, 1'b1, 1'b0);
    hit("R7 sre3 on sre2 off", 1'b1, 4'd10, 2'd3, 3'b101, 1'b0, 1'b1);
    // R9 same request, both directions
    hit("R9 read", 1'b0, 4'd5, 2'd3, 3'b000, 1'b0, 1'b1);
    hit("R9 write", 1'b1, 4'd5, 2'd3, 3'b000, 1'b0, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R8 idle after traffic");
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results got=%0d pending expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule